// File: doc/BRIEF.md
# Execute Stage with Pre-Shifted First Operand

This block is the 32-bit execute stage of a small load/store core. The barrel shifter sits in front of the first source operand, not the second. The second source goes to the adder as it is. A subtract therefore computes the shifted first operand minus the plain second operand. A reverse subtract computes the plain second operand minus the shifted first operand.

Four operations are supported: add, add-with-carry, subtract and reverse subtract. The block keeps its own N, Z, C and V flag register. That register is written only when the instruction asks for a flag update and the instruction's condition field passes against the current flags. The write-enable for the destination register is the condition result.

The result, the write-enable and the flag vector are all registered. They appear one clock after their inputs are presented.

Top module: `preshift_alu`

## Requirements
- R1: The op code `aluOp` selects one of four operations: 00 = shifted A + B, 01 = shifted A + B + current C, 10 = shifted A − B, 11 = B − shifted A. B is never shifted. `resOut` shows the 32-bit result one clock after the inputs are presented.
- R2: The shift kind `shiftKind` selects one of four shifts: 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. Each shifts A by `shiftAmt` (0..31). An arithmetic right shift by n equals signed division by 2^n rounded toward negative infinity; for example, −100 shifted right by 5 gives −4.
- R3: A shift amount of 0 passes A through unchanged, whatever the shift kind.
- R4: The flag vector `flagsOut` = {N,Z,C,V} (bit 3 = N, bit 0 = V) is loaded only when `setFlags` is 1 and the condition passes. Otherwise it keeps its value, even when the operation carries or overflows.
- R5: For ops 00 and 01, C is the carry out of bit 31 of the unsigned sum. For example, 0xAB000000 + 0xA2000000 sets C. Op 01 adds the current C as carry-in.
- R6: For ops 10 and 11, C is the inverted borrow: C = 1 exactly when the minuend is greater than or equal to the subtrahend as unsigned values.
- R7: V is 1 exactly when the signed result of the operation does not fit in 32 bits.
- R8: N is bit 31 of the ALU result. Z is 1 exactly when all 32 result bits are zero.
- R9: The condition field `cond` is decoded against the current flags: 0 = Z set, 1 = Z clear, 2 = C set, 3 = C clear, 4 = N set, 5 = N clear, 6 = V set, 7 = V clear, 14 = always. Every other code never passes. `wrEn` shows the pass result one clock later.
- R10: While `rst` is high at a clock edge, `resOut`, `wrEn` and `flagsOut` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 32 | First source operand, goes through the shifter |
| opB | input | 32 | Second source operand, unshifted |
| shiftKind | input | 2 | Shift kind applied to opA |
| shiftAmt | input | 5 | Shift distance for opA |
| aluOp | input | 2 | Operation select |
| setFlags | input | 1 | Request a flag update |
| cond | input | 4 | Condition code |
| resOut | output | 32 | Registered ALU result |
| wrEn | output | 1 | Registered destination write-enable (condition passed) |
| flagsOut | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The properties treat every input as a fresh value on each clock. They rely on no relation between consecutive instructions, apart from the flags the block itself holds. The hold and condition-fail properties assume that `rst` stays low across the cycle they compare, and the stimulus raises reset only at the start of the run.

The random stimulus covers every shift kind, amount, op and condition code, including the codes that never pass. Directed cases cover the carry-out example, the arithmetic-shift division, add-with-carry with C set, and an overflow with `setFlags` low.

// File: rtl/preshift_alu_pkg.sv
`timescale 1ns/1ps
package preshift_alu_pkg;
  localparam int unsigned DataW  = 32;
  localparam int unsigned ShAmtW = $clog2(DataW);

  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_ADC = 2'b01;
  localparam logic [1:0] OP_SUB = 2'b10;
  localparam logic [1:0] OP_RSB = 2'b11;

  localparam logic [1:0] SH_LSL = 2'b00;
  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ASR = 2'b10;
  localparam logic [1:0] SH_ROR = 2'b11;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic passCond;
    logic updFlags;
    logic carryIn;
  } ctrl_t;
endpackage

// File: rtl/preshift_alu_ctrl.sv
`timescale 1ns/1ps
module preshift_alu_ctrl
  import preshift_alu_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     curFlags,
  input  logic       setFlags,
  input  logic [1:0] aluOp,
  output ctrl_t      strb
);
  logic condOk;

  always_comb begin
    unique case (cond)
      4'd0:    condOk = curFlags.z;
      4'd1:    condOk = !curFlags.z;
      4'd2:    condOk = curFlags.c;
      4'd3:    condOk = !curFlags.c;
      4'd4:    condOk = curFlags.n;
      4'd5:    condOk = !curFlags.n;
      4'd6:    condOk = curFlags.v;
      4'd7:    condOk = !curFlags.v;
      4'd14:   condOk = 1'b1;
      default: condOk = 1'b0;
    endcase
  end

  always_comb begin
    strb.passCond = condOk;
    strb.updFlags = condOk && setFlags;
    strb.carryIn  = (aluOp == OP_ADC) ? curFlags.c : 1'b0;
  end
endmodule

// File: rtl/preshift_alu_dp.sv
`timescale 1ns/1ps
module preshift_alu_dp
  import preshift_alu_pkg::*;
#(
  parameter int unsigned W  = DataW,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [1:0]    shiftKind,
  input  logic [SW-1:0] shiftAmt,
  input  logic [1:0]    aluOp,
  input  ctrl_t         strb,
  output logic [W-1:0]  resOut,
  output logic          wrEn,
  output flags_t        curFlags
);
  logic [W-1:0]   shifted;
  logic [2*W-1:0] rotWide;
  logic [W-1:0]   addX, addY;
  logic           addCin;
  logic [W:0]     addSum;
  flags_t         nextFlags;

  // shifter on the first operand path
  assign rotWide = {opA, opA} >> shiftAmt;

  always_comb begin
    unique case (shiftKind)
      SH_LSL:  shifted = opA << shiftAmt;
      SH_LSR:  shifted = opA >> shiftAmt;
      SH_ASR:  shifted = W'($signed(opA) >>> shiftAmt);
      default: shifted = rotWide[W-1:0];
    endcase
  end

  // single adder; subtraction by inverted addend plus one
  always_comb begin
    unique case (aluOp)
      OP_ADD:  begin addX = shifted; addY = opB;      addCin = 1'b0;         end
      OP_ADC:  begin addX = shifted; addY = opB;      addCin = strb.carryIn; end
      OP_SUB:  begin addX = shifted; addY = ~opB;     addCin = 1'b1;         end
      default: begin addX = opB;     addY = ~shifted; addCin = 1'b1;         end
    endcase
  end

  assign addSum = {1'b0, addX} + {1'b0, addY} + {{W{1'b0}}, addCin};

  always_comb begin
    nextFlags.n = addSum[W-1];
    nextFlags.z = (addSum[W-1:0] == '0);
    nextFlags.c = addSum[W];
    nextFlags.v = (addX[W-1] == addY[W-1]) && (addSum[W-1] != addX[W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resOut   <= '0;
      wrEn     <= 1'b0;
      curFlags <= '0;
    end else begin
      resOut <= addSum[W-1:0];
      wrEn   <= strb.passCond;
      if (strb.updFlags) curFlags <= nextFlags;
    end
  end
endmodule

// File: rtl/preshift_alu.sv
`timescale 1ns/1ps
module preshift_alu
  import preshift_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  shiftKind,
  input  logic [4:0]  shiftAmt,
  input  logic [1:0]  aluOp,
  input  logic        setFlags,
  input  logic [3:0]  cond,
  output logic [31:0] resOut,
  output logic        wrEn,
  output logic [3:0]  flagsOut
);
  ctrl_t  strb;
  flags_t curFlags;

  preshift_alu_ctrl u_ctrl (
    .cond     (cond),
    .curFlags (curFlags),
    .setFlags (setFlags),
    .aluOp    (aluOp),
    .strb     (strb)
  );

  preshift_alu_dp #(.W(DataW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .opA       (opA),
    .opB       (opB),
    .shiftKind (shiftKind),
    .shiftAmt  (shiftAmt),
    .aluOp     (aluOp),
    .strb      (strb),
    .resOut    (resOut),
    .wrEn      (wrEn),
    .curFlags  (curFlags)
  );

  assign flagsOut = curFlags;
endmodule

// File: rtl/preshift_alu_chk.sv
`timescale 1ns/1ps
module preshift_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [4:0]  shiftAmt,
  input logic [1:0]  aluOp,
  input logic        setFlags,
  input logic [3:0]  cond,
  input logic [31:0] resOut,
  input logic        wrEn,
  input logic [3:0]  flagsOut
);
  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (resOut == 32'd0 && !wrEn && flagsOut == 4'd0));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !setFlags |=> $stable(flagsOut));

  // R9
  always_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'd14) |=> wrEn);

  // R9
  eq_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'd0 && !flagsOut[2]) |=> (!wrEn && $stable(flagsOut)));

  // R8
  nz_from_result_chk: assert property (@(posedge clk) disable iff (rst)
    (setFlags && cond == 4'd14) |=>
      (flagsOut[3] == resOut[31] && flagsOut[2] == (resOut == 32'd0)));

  // R3
  zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shiftAmt == 5'd0 && aluOp == 2'b00 && opB == 32'd0) |=> (resOut == $past(opA)));
endmodule

bind preshift_alu preshift_alu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .opA      (opA),
  .opB      (opB),
  .shiftAmt (shiftAmt),
  .aluOp    (aluOp),
  .setFlags (setFlags),
  .cond     (cond),
  .resOut   (resOut),
  .wrEn     (wrEn),
  .flagsOut (flagsOut)
);

// File: tb/preshift_alu_test.sv
`timescale 1ns/1ps
module preshift_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  shiftKind = '0, aluOp = '0;
  logic [4:0]  shiftAmt = '0;
  logic        setFlags = 1'b0;
  logic [3:0]  cond = 4'd14;
  logic [31:0] resOut;
  logic        wrEn;
  logic [3:0]  flagsOut;

  int nChecks = 0;
  int nFails  = 0;
  logic mN = 0, mZ = 0, mC = 0, mV = 0;

  always #2.5 clk = ~clk;

  preshift_alu uut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .shiftKind(shiftKind),
    .shiftAmt(shiftAmt), .aluOp(aluOp), .setFlags(setFlags), .cond(cond),
    .resOut(resOut), .wrEn(wrEn), .flagsOut(flagsOut)
  );

  function automatic logic [31:0] refShift(input logic [31:0] a, input logic [1:0] k,
                                           input logic [4:0] n);
    longint signed sa;
    logic [31:0] r;
    sa = longint'($signed(a));
    case (k)
      2'd0: r = a << n;
      2'd1: r = a >> n;
      2'd2: r = 32'(sa >>> n);
      default: r = (n == 0) ? a : ((a >> n) | (a << (32 - n)));
    endcase
    return r;
  endfunction

  // returns {C,V,result}
  function automatic logic [33:0] refAlu(input logic [31:0] x, input logic [31:0] b,
                                         input logic [1:0] op, input logic cin);
    longint unsigned ux, ub, u;
    longint signed sx, sb, s;
    logic c;
    ux = longint'(x); ub = longint'(b);
    sx = longint'($signed(x)); sb = longint'($signed(b));
    case (op)
      2'd0: begin u = ux + ub; s = sx + sb; c = (u >= 64'h1_0000_0000); end
      2'd1: begin u = ux + ub + longint'(cin); s = sx + sb + longint'(cin);
                  c = (u >= 64'h1_0000_0000); end
      2'd2: begin u = ux - ub; s = sx - sb; c = (ux >= ub); end
      default: begin u = ub - ux; s = sb - sx; c = (ub >= ux); end
    endcase
    return {c, (s > 64'sd2147483647) || (s < -64'sd2147483648), u[31:0]};
  endfunction

  function automatic logic refCond(input logic [3:0] cd);
    case (cd)
      4'd0: return mZ;   4'd1: return !mZ;
      4'd2: return mC;   4'd3: return !mC;
      4'd4: return mN;   4'd5: return !mN;
      4'd6: return mV;   4'd7: return !mV;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] sk,
                      input logic [4:0] sa, input logic [1:0] op, input logic sf,
                      input logic [3:0] cd, input string tag);
    logic [31:0] sh, er;
    logic [33:0] r;
    logic pass;
    logic [3:0] ef;
    opA = a; opB = b; shiftKind = sk; shiftAmt = sa; aluOp = op;
    setFlags = sf; cond = cd;
    sh = refShift(a, sk, sa);
    r = refAlu(sh, b, op, mC);
    er = r[31:0];
    pass = refCond(cd);
    if (pass && sf) ef = {er[31], er == 32'd0, r[33], r[32]};
    else ef = {mN, mZ, mC, mV};
    @(posedge clk);
    @(negedge clk);
    check(resOut == er, {tag, " result R1"}, resOut, er);
    check(wrEn == pass, {tag, " wrEn R9"}, 32'(wrEn), 32'(pass));
    check(flagsOut == ef, {tag, " flags R4"}, 32'(flagsOut), 32'(ef));
    {mN, mZ, mC, mV} = ef;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(resOut == 32'd0, "R10 result", resOut, 32'd0);
    check(wrEn == 1'b0, "R10 wrEn", 32'(wrEn), 32'd0);
    check(flagsOut == 4'd0, "R10 flags", 32'(flagsOut), 32'd0);
    rst = 1'b0;

    // R5 carry out example, sets C
    step(32'hAB00_0000, 32'hA200_0000, 2'd0, 5'd0, 2'd0, 1'b1, 4'd14, "R5 carry");
    check(flagsOut[1] == 1'b1, "R5 C set", 32'(flagsOut[1]), 32'd1);
    // R5 add-with-carry with C=1: one more than plain sum
    step(32'd10, 32'd20, 2'd0, 5'd0, 2'd1, 1'b0, 4'd14, "R5 adc");
    check(resOut == 32'd31, "R5 adc value", resOut, 32'd31);
    // R2 arithmetic shift right by 5 = floor division by 32
    step(32'hFFFF_FF9C, 32'd0, 2'd2, 5'd5, 2'd0, 1'b1, 4'd14, "R2 asr");
    check(resOut == 32'hFFFF_FFFC, "R2 asr floor", resOut, 32'hFFFF_FFFC);
    // R1 SUB: (A<<3) - B
    step(32'd5, 32'd7, 2'd0, 5'd3, 2'd2, 1'b1, 4'd14, "R1 sub");
    check(resOut == 32'd33, "R1 shifted minuend", resOut, 32'd33);
    check(flagsOut[1] == 1'b1, "R6 no borrow", 32'(flagsOut[1]), 32'd1);
    // R6 reverse subtract with borrow
    step(32'd1, 32'd3, 2'd0, 5'd2, 2'd3, 1'b1, 4'd14, "R6 rsb");
    check(flagsOut[1] == 1'b0, "R6 borrow", 32'(flagsOut[1]), 32'd0);
    // R3 amount zero passes through for every kind
    for (int k = 0; k < 4; k++)
      step(32'h8765_4321, 32'd0, 2'(k), 5'd0, 2'd0, 1'b0, 4'd14, "R3 zero amount");
    // R7 overflow with setFlags clear: flags unchanged
    step(32'h7FFF_FFFF, 32'd1, 2'd0, 5'd0, 2'd0, 1'b0, 4'd14, "R4 no set");
    // R7 overflow with setFlags: V set, N set
    step(32'h7FFF_FFFF, 32'd1, 2'd0, 5'd0, 2'd0, 1'b1, 4'd14, "R7 ovf");
    check(flagsOut == 4'b1001, "R7 R8 flags", 32'(flagsOut), 32'b1001);
    // R9 EQ fails with Z=0
    step(32'd0, 32'd0, 2'd0, 5'd0, 2'd0, 1'b1, 4'd0, "R9 eq fail");
    // R8 zero result sets Z, then EQ passes
    step(32'd4, 32'd4, 2'd0, 5'd0, 2'd2, 1'b1, 4'd14, "R8 zero");
    step(32'd1, 32'd1, 2'd0, 5'd0, 2'd0, 1'b1, 4'd0, "R9 eq pass");
    // R2 rotate
    step(32'h0000_00F1, 32'd0, 2'd3, 5'd4, 2'd0, 1'b0, 4'd14, "R2 ror");
    check(resOut == 32'h1000_000F, "R2 ror value", resOut, 32'h1000_000F);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 7 == 0) a = 32'h8000_0000 ^ b;
      step(a, b, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 15)), "R2 R5 R6 R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule